// File: doc/BRIEF.md
# DMA Channel Start-Source and Destination-Address Control

This block is the control slice of one DMA channel running with full 24-bit addresses. A single control byte, written through a small register port, enables the channel, picks the event that may start a transfer, sets whether the destination pointer moves after each transfer, and records which side of a block transfer is the repeating area. The block turns the chosen start condition into a transfer request for the bus side. It also keeps the destination address, stepping it by one byte or one word each time the bus side reports a completed transfer.

The start condition can be one of several sources. Two are auto-request modes: burst, where the request is held, and cycle-steal, where the request gives up the bus for a cycle after every transfer. Three timer compare-match pulses and an ADC conversion-done pulse are also available. The last two sources use the active-low external request pin, sensed either on its falling edge or on its low level. Select codes that name none of these sources leave the request low. Source-address handling, arbitration, transfer counting and interrupts are handled elsewhere.

Top module: `dmac_dst_chan`

## Requirements
- R1: After reset the enable bit (control bit 0) is 0. While it is 0, `xferReq` and `burstMode` stay 0 whatever the inputs are.
- R2: A write with `regSel`=0 loads control bits [7:0] from `regWrData[7:0]`: bit0 enable, bit1 step-enable, bit2 direction (1 = down), bit3 block side (1 = source is the block area), bits[7:4] start select. All bits reset to 0. Bit3 is shown on `blockSrcSide` in the cycle after the write.
- R3: While step-enable is 0, a `xferDone` strobe leaves `dstAddr` unchanged for either direction.
- R4: With step-enable 1 and direction 0, each `xferDone` raises `dstAddr` by 1 when `xferWord`=0 and by 2 when `xferWord`=1. The new value appears in the cycle after the strobe.
- R5: With step-enable 1 and direction 1, each `xferDone` lowers `dstAddr` by the same step. Stepping wraps modulo 2^24 in both directions.
- R6: A write with `regSel`=1 loads `dstAddr` from `regWrData` in the next cycle. If a `xferDone` strobe arrives in the same cycle, the write takes priority over the step.
- R7: Select 0 (auto, burst): while enabled, `xferReq`=1 and `burstMode`=1, and transfer strobes do not drop the request.
- R8: Select 1 (auto, cycle-steal): while enabled, `xferReq`=1 except in the single cycle that follows each `xferDone` strobe, when it is 0.
- R9: Selects 2, 3 and 4 take timer pulses `tmrMatch[0]`, `[1]` and `[2]`, and select 5 takes `adcDone`. A pulse on the selected input sets `xferReq` in the next cycle, and it stays set until the cycle after a `xferDone` strobe. Pulses on inputs that are not selected have no effect. A control write clears any pending request.
- R10: Select 6 (pin, falling edge): `reqPinN` passes through a two-stage synchronizer. A high-to-low change sets a pending request that shows on `xferReq` three cycles after the pin falls. It is held until a `xferDone` strobe.
- R11: Select 7 (pin, low level): `xferReq` follows the inverted synchronized pin and rises two cycles after the pin goes low.
- R12: Select codes 8 to 15 are unavailable. They never raise `xferReq`, even when timers, the ADC, the pin or auto-request conditions are active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| regWrEn | input | 1 | Register write strobe |
| regSel | input | 1 | 0 = control byte, 1 = destination address |
| regWrData | input | 24 | Write data |
| xferWord | input | 1 | Transfer size: 0 byte, 1 word |
| reqPinN | input | 1 | External request pin, active low, asynchronous |
| tmrMatch | input | 3 | Compare-match pulses from timer channels 0 to 2 |
| adcDone | input | 1 | ADC conversion-done pulse |
| xferDone | input | 1 | One-cycle strobe for a completed transfer |
| xferReq | output | 1 | Transfer request to the bus side |
| burstMode | output | 1 | Channel enabled in auto-request burst mode |
| blockSrcSide | output | 1 | Block-area side bit from the control byte |
| dstAddr | output | 24 | Current destination address |

## Verification
Register writes and `xferDone` steps show up one cycle after the strobe edge. The cycle-steal gap falls in that same cycle and has cleared by the next one. Timer and ADC pending requests show one cycle after the pulse, the level-sensed pin two cycles after it falls, and the edge-sensed pin three. The bench drives every input on a falling clock edge and counts rising edges to each due cycle, then samples on the following falling edge. It also samples one cycle early on the pin paths to confirm that the request has not yet risen.

// File: rtl/dmac_pkg.sv
`timescale 1ns/1ps
package dmac_pkg;
  localparam int NUM_TMR = 3;

  typedef enum logic [3:0] {
    SRC_AUTO_BURST = 4'd0,
    SRC_AUTO_CYCLE = 4'd1,
    SRC_TMR0       = 4'd2,
    SRC_TMR1       = 4'd3,
    SRC_TMR2       = 4'd4,
    SRC_ADC        = 4'd5,
    SRC_PIN_FALL   = 4'd6,
    SRC_PIN_LOW    = 4'd7
  } srcSel_e;

  typedef struct packed {
    logic [3:0] sel;
    logic       blockSrc;
    logic       down;
    logic       stepEn;
    logic       enable;
  } ctrlReg_t;

  // strobes from control to the address datapath
  typedef struct packed {
    logic load;
    logic step;
    logic down;
    logic word;
  } addrCmd_t;
endpackage

// File: rtl/dmac_ctrl.sv
`timescale 1ns/1ps
module dmac_ctrl
  import dmac_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWrEn,
  input  logic               regSel,
  input  logic [7:0]         wrByte,
  input  logic               xferWord,
  input  logic               reqPinN,
  input  logic [NUM_TMR-1:0] tmrMatch,
  input  logic               adcDone,
  input  logic               xferDone,
  output logic               xferReq,
  output logic               burstMode,
  output logic               blockSrcSide,
  output addrCmd_t           cmd
);
  ctrlReg_t ctrlQ;
  logic     ctrlWr;
  logic     pinS1, pinS2, pinPrev;
  logic     fallDet;
  logic     evHit, pendSrc, pendQ, doneQ;
  logic [NUM_TMR-1:0] tmrSel;

  assign ctrlWr = regWrEn & ~regSel;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ctrlQ <= '0;
    else if (ctrlWr) ctrlQ <= ctrlReg_t'(wrByte);
  end

  // two-stage synchronizer plus history for edge detection, idle high
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pinS1   <= 1'b1;
      pinS2   <= 1'b1;
      pinPrev <= 1'b1;
    end else begin
      pinS1   <= reqPinN;
      pinS2   <= pinS1;
      pinPrev <= pinS2;
    end
  end
  assign fallDet = pinPrev & ~pinS2;

  // one decode per timer channel
  for (genvar t = 0; t < NUM_TMR; t++) begin : g_tmr
    assign tmrSel[t] = (ctrlQ.sel == 4'(int'(SRC_TMR0) + t)) & tmrMatch[t];
  end

  always_comb begin
    evHit   = 1'b0;
    pendSrc = 1'b0;
    case (ctrlQ.sel)
      SRC_TMR0, SRC_TMR1, SRC_TMR2: begin evHit = |tmrSel;  pendSrc = 1'b1; end
      SRC_ADC:                      begin evHit = adcDone;  pendSrc = 1'b1; end
      SRC_PIN_FALL:                 begin evHit = fallDet;  pendSrc = 1'b1; end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendQ <= 1'b0;
      doneQ <= 1'b0;
    end else begin
      doneQ <= xferDone;
      if (ctrlWr || !ctrlQ.enable) pendQ <= 1'b0;
      else if (evHit)              pendQ <= 1'b1;
      else if (xferDone)           pendQ <= 1'b0;
    end
  end

  always_comb begin
    xferReq = 1'b0;
    if (ctrlQ.enable) begin
      case (ctrlQ.sel)
        SRC_AUTO_BURST: xferReq = 1'b1;
        SRC_AUTO_CYCLE: xferReq = ~doneQ;
        SRC_PIN_LOW:    xferReq = ~pinS2;
        default:        xferReq = pendSrc & pendQ;
      endcase
    end
  end

  assign burstMode    = ctrlQ.enable & (ctrlQ.sel == SRC_AUTO_BURST);
  assign blockSrcSide = ctrlQ.blockSrc;

  assign cmd.load = regWrEn & regSel;
  assign cmd.step = xferDone & ctrlQ.stepEn;
  assign cmd.down = ctrlQ.down;
  assign cmd.word = xferWord;

  p_off_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlQ.enable |-> (!xferReq && !burstMode));

  p_cs_gap_r8: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlQ.enable && ctrlQ.sel == SRC_AUTO_CYCLE && xferDone && !ctrlWr) |=> !xferReq);

  p_event_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlQ.enable && pendSrc && xferReq && !xferDone && !ctrlWr) |=> xferReq);

  p_bad_code_r12: assert property (@(posedge clk) disable iff (!rstN)
    ctrlQ.sel[3] |-> !xferReq);
endmodule

// File: rtl/dmac_addr.sv
`timescale 1ns/1ps
module dmac_addr
  import dmac_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  addrCmd_t          cmd,
  input  logic [ADDR_W-1:0] wrData,
  output logic [ADDR_W-1:0] addr
);
  logic [ADDR_W-1:0] addrQ, delta;

  assign delta = cmd.word ? ADDR_W'(2) : ADDR_W'(1);

  // load wins over step; arithmetic wraps at the register width
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          addrQ <= '0;
    else if (cmd.load)  addrQ <= wrData;
    else if (cmd.step)  addrQ <= cmd.down ? addrQ - delta : addrQ + delta;
  end
  assign addr = addrQ;

  p_fixed_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!cmd.load && !cmd.step) |=> $stable(addrQ));

  p_step_up_r4: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.step && !cmd.load && !cmd.down) |=>
      addrQ == $past(addrQ) + ($past(cmd.word) ? ADDR_W'(2) : ADDR_W'(1)));

  p_step_down_r5: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.step && !cmd.load && cmd.down) |=>
      addrQ == $past(addrQ) - ($past(cmd.word) ? ADDR_W'(2) : ADDR_W'(1)));

  p_load_r6: assert property (@(posedge clk) disable iff (!rstN)
    cmd.load |=> addrQ == $past(wrData));
endmodule

// File: rtl/dmac_dst_chan.sv
`timescale 1ns/1ps
module dmac_dst_chan
  import dmac_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regSel,
  input  logic [ADDR_W-1:0] regWrData,
  input  logic              xferWord,
  input  logic              reqPinN,
  input  logic [2:0]        tmrMatch,
  input  logic              adcDone,
  input  logic              xferDone,
  output logic              xferReq,
  output logic              burstMode,
  output logic              blockSrcSide,
  output logic [ADDR_W-1:0] dstAddr
);
  addrCmd_t cmd;

  dmac_ctrl u_ctrl (
    .clk, .rstN, .regWrEn, .regSel,
    .wrByte(regWrData[7:0]),
    .xferWord, .reqPinN, .tmrMatch, .adcDone, .xferDone,
    .xferReq, .burstMode, .blockSrcSide, .cmd
  );

  dmac_addr #(.ADDR_W(ADDR_W)) u_addr (
    .clk, .rstN, .cmd,
    .wrData(regWrData),
    .addr(dstAddr)
  );
endmodule

// File: tb/dmac_dst_chan_test.sv
`timescale 1ns/1ps
module dmac_dst_chan_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0, regSel = 1'b0;
  logic [23:0] regWrData = '0;
  logic        xferWord = 1'b0, reqPinN = 1'b1;
  logic [2:0]  tmrMatch = '0;
  logic        adcDone = 1'b0, xferDone = 1'b0;
  logic        xferReq, burstMode, blockSrcSide;
  logic [23:0] dstAddr;
  int          nRun = 0, nFail = 0;

  always #2.5 clk = ~clk;

  dmac_dst_chan uut (.*);

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] ctl(bit en, bit step, bit down, bit blk, logic [3:0] sel);
    return {sel, blk, down, step, en};
  endfunction

  task automatic wrCtrl(input logic [7:0] v);
    @(negedge clk); regWrEn = 1; regSel = 0; regWrData = {16'h0, v};
    @(negedge clk); regWrEn = 0;
  endtask

  task automatic wrAddr(input logic [23:0] v);
    @(negedge clk); regWrEn = 1; regSel = 1; regWrData = v;
    @(negedge clk); regWrEn = 0;
  endtask

  task automatic pulseDone(input bit word);
    @(negedge clk); xferDone = 1; xferWord = word;
    @(negedge clk); xferDone = 0;
  endtask

  task automatic t_reset;
    check(xferReq == 0, "R1 reset req", xferReq, 0);
    check(burstMode == 0, "R1 reset burst", burstMode, 0);
    check(blockSrcSide == 0, "R2 reset block side", blockSrcSide, 0);
    check(dstAddr == 0, "R2 reset addr", dstAddr, 0);
  endtask

  task automatic t_disabled;
    wrCtrl(ctl(0, 0, 0, 0, 4'd0));
    check(xferReq == 0, "R1 burst while off", xferReq, 0);
    wrCtrl(ctl(0, 0, 0, 0, 4'd7));
    @(negedge clk); reqPinN = 0;
    repeat (3) @(negedge clk);
    check(xferReq == 0, "R1 level pin while off", xferReq, 0);
    reqPinN = 1; repeat (3) @(negedge clk);
  endtask

  task automatic t_blockside;
    wrCtrl(ctl(0, 0, 0, 1, 4'd0));
    check(blockSrcSide == 1, "R2 block side set", blockSrcSide, 1);
    wrCtrl(ctl(0, 0, 0, 0, 4'd0));
    check(blockSrcSide == 0, "R2 block side clear", blockSrcSide, 0);
  endtask

  task automatic t_burst;
    wrCtrl(ctl(1, 0, 0, 0, 4'd0));
    check(xferReq == 1 && burstMode == 1, "R7 burst on", {xferReq, burstMode}, 2'b11);
    pulseDone(0);
    check(xferReq == 1, "R7 burst after done", xferReq, 1);
    wrCtrl(ctl(0, 0, 0, 0, 4'd0));
    check(xferReq == 0 && burstMode == 0, "R1 burst disabled", {xferReq, burstMode}, 0);
  endtask

  task automatic t_cycle;
    wrCtrl(ctl(1, 0, 0, 0, 4'd1));
    check(xferReq == 1, "R8 cycle steal on", xferReq, 1);
    check(burstMode == 0, "R8 not burst", burstMode, 0);
    pulseDone(0);
    check(xferReq == 0, "R8 gap after done", xferReq, 0);
    @(negedge clk);
    check(xferReq == 1, "R8 request back", xferReq, 1);
  endtask

  task automatic t_addr;
    wrAddr(24'h123456);
    check(dstAddr == 24'h123456, "R6 load", dstAddr, 24'h123456);
    wrCtrl(ctl(1, 0, 1, 0, 4'd0));
    pulseDone(1);
    check(dstAddr == 24'h123456, "R3 fixed", dstAddr, 24'h123456);
    wrCtrl(ctl(1, 1, 0, 0, 4'd0));
    pulseDone(0);
    check(dstAddr == 24'h123457, "R4 inc byte", dstAddr, 24'h123457);
    pulseDone(1);
    check(dstAddr == 24'h123459, "R4 inc word", dstAddr, 24'h123459);
    wrAddr(24'hFFFFFF);
    pulseDone(0);
    check(dstAddr == 24'h000000, "R5 wrap up", dstAddr, 0);
    wrCtrl(ctl(1, 1, 1, 0, 4'd0));
    wrAddr(24'h000001);
    pulseDone(1);
    check(dstAddr == 24'hFFFFFF, "R5 wrap down word", dstAddr, 24'hFFFFFF);
    pulseDone(0);
    check(dstAddr == 24'hFFFFFE, "R5 dec byte", dstAddr, 24'hFFFFFE);
    @(negedge clk); regWrEn = 1; regSel = 1; regWrData = 24'hABCDEF; xferDone = 1;
    @(negedge clk); regWrEn = 0; xferDone = 0;
    check(dstAddr == 24'hABCDEF, "R6 load beats step", dstAddr, 24'hABCDEF);
  endtask

  task automatic t_events;
    for (int i = 0; i < 4; i++) begin
      wrCtrl(ctl(1, 0, 0, 0, 4'(2 + i)));
      @(negedge clk);
      if (i < 3) tmrMatch = 3'b111 & ~(3'b1 << i); else tmrMatch = 3'b111;
      @(negedge clk); tmrMatch = 0;
      check(xferReq == 0, "R9 other source ignored", xferReq, 0);
      if (i < 3) tmrMatch = 3'(1 << i); else adcDone = 1;
      @(negedge clk); tmrMatch = 0; adcDone = 0;
      check(xferReq == 1, "R9 event sets request", xferReq, 1);
      repeat (2) @(negedge clk);
      check(xferReq == 1, "R9 request held", xferReq, 1);
      pulseDone(0);
      check(xferReq == 0, "R9 cleared by done", xferReq, 0);
    end
  endtask

  task automatic t_pin_edge;
    wrCtrl(ctl(1, 0, 0, 0, 4'd6));
    @(negedge clk); reqPinN = 0;
    @(negedge clk);
    check(xferReq == 0, "R10 not yet after 1 edge", xferReq, 0);
    repeat (2) @(negedge clk);
    check(xferReq == 1, "R10 edge after 3 edges", xferReq, 1);
    reqPinN = 1;
    repeat (3) @(negedge clk);
    check(xferReq == 1, "R10 latched after pin high", xferReq, 1);
    pulseDone(0);
    check(xferReq == 0, "R10 cleared by done", xferReq, 0);
  endtask

  task automatic t_pin_level;
    wrCtrl(ctl(1, 0, 0, 0, 4'd7));
    @(negedge clk); reqPinN = 0;
    @(negedge clk);
    check(xferReq == 0, "R11 not yet after 1 edge", xferReq, 0);
    @(negedge clk);
    check(xferReq == 1, "R11 level after 2 edges", xferReq, 1);
    reqPinN = 1;
    repeat (2) @(negedge clk);
    check(xferReq == 0, "R11 follows pin high", xferReq, 0);
  endtask

  task automatic t_bad_codes;
    for (int c = 8; c < 16; c++) begin
      wrCtrl(ctl(1, 0, 0, 0, 4'(c)));
      @(negedge clk); reqPinN = 0; tmrMatch = 3'b111; adcDone = 1;
      repeat (3) @(negedge clk);
      check(xferReq == 0, "R12 unavailable code", xferReq, 0);
      tmrMatch = 0; adcDone = 0; reqPinN = 1;
      repeat (3) @(negedge clk);
      check(xferReq == 0, "R12 unavailable code idle", xferReq, 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rstN = 1;
    @(negedge clk);
    t_reset();
    t_disabled();
    t_blockside();
    t_burst();
    t_cycle();
    t_addr();
    t_events();
    t_pin_edge();
    t_pin_level();
    t_bad_codes();
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    nRun++; nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule